// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sequences conversions for an external 12-bit analog-to-digital converter that sits behind an 8-way input multiplexer and a programmable-gain amplifier. Software programs it through byte-wide write registers: gain code, input channel, mode, software trigger and interrupt acknowledge. The 3-bit mode code chooses the trigger source (software write or pacer pulse) and the transfer type (polled or interrupt). Each conversion is a start pulse to the converter, followed later by a done pulse carrying the 12-bit sample.

The result and a busy flag can be read back as two bytes. A change of gain code starts a settling guard measured in clock cycles, and a trigger that arrives during the guard is held until it expires. A trigger that arrives while a conversion is pending or running is dropped and counted. In interrupt mode a sticky flag is set by every completed conversion and is driven on one chosen request line until software acknowledges it.

Top module: `conv_seq_top`

## Requirements
- R1: After reset, busy is 0, both read bytes are 0x00, all request lines are 0, the overrun count is 0, and the gain, channel and mode codes are 000.
- R2: With read select 0 the read byte is result bits 7..0. With read select 1 it is {0,0,0,busy,result bits 11..8}. A result is captured on the converter done pulse of a running conversion.
- R3: Register select 3 is the software trigger. In mode 000 or 001, a write of any data value produces exactly one start pulse, in the cycle after the write edge (when no settling is pending). Busy stays 1 from then until the done pulse.
- R4: A pacer pulse starts a conversion only in mode 010 or 110. A software trigger starts one only in mode 000 or 001. In modes 011, 100, 101 and 111 both sources are ignored: no start and no busy.
- R5: In mode 010 or 110, a one-cycle pacer pulse produces a start pulse in the cycle after the edge that samples it.
- R6: A trigger that arrives while busy is 1 produces no start pulse. It increments the overrun count, which stops at its maximum (255 by default).
- R7: A gain-code write (register select 0, bits 2..0) whose code differs from the current one loads a settling count of ceil(t x f_clk) cycles. t is 2.1, 2.5, 2.7, 3.6 or 4.1 us for codes 000 to 100, and 4.1 us for codes 101 to 111. A trigger is held, with busy 1, and the start pulse comes S clock edges after the gain write edge. Rewriting the same code loads nothing.
- R8: Register select 1 bits 2..0 drive the channel output as plain binary, and bits 7..3 are ignored. The gain output carries the stored gain code.
- R9: Mode byte bits 2..0 are the mode code. In mode 110 each completed conversion sets a sticky interrupt flag, which stays set until any value is written to register select 4. In other modes no flag is set and no line is driven.
- R10: Mode byte bits 6..4 choose the request line: codes 000 and 010 drive line 2, code 001 drives none, and codes 011 to 111 drive lines 3 to 7. At most one line is driven.
- R11: When a conversion completes in the same cycle as an acknowledge write, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write register select (0 gain, 1 channel, 2 mode, 3 trigger, 4 acknowledge) |
| wr_data_i | input | 8 | Write data byte |
| rd_sel_i | input | 1 | Read byte select (0 low, 1 high/busy) |
| rd_data_o | output | 8 | Read byte |
| pacer_i | input | 1 | Pacer trigger pulse |
| conv_start_o | output | 1 | Start pulse to converter |
| conv_chan_o | output | 3 | Multiplexer channel |
| conv_gain_o | output | 3 | Amplifier gain code |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | 12 | Converter sample |
| busy_o | output | 1 | Conversion pending or running |
| irq_o | output | 8 | Interrupt request lines |
| overrun_o | output | 8 | Dropped-trigger count |

## Verification
A converter done pulse and a software acknowledge write can land on the same clock edge, and the flag then has a set and a clear pending at once. The bench provokes this by watching its converter model. In the very cycle it sees the done pulse raised, it issues the acknowledge write, so that both are sampled on the same edge. It then judges that the request line is still driven. A second, separate acknowledge must then clear the line.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_CONV} sq_state_e;

  localparam logic [2:0] RS_GAIN = 3'd0;
  localparam logic [2:0] RS_CHAN = 3'd1;
  localparam logic [2:0] RS_MODE = 3'd2;
  localparam logic [2:0] RS_TRIG = 3'd3;
  localparam logic [2:0] RS_ACK  = 3'd4;

  localparam logic [2:0] MD_SW_A  = 3'b000;
  localparam logic [2:0] MD_SW_B  = 3'b001;
  localparam logic [2:0] MD_PACER = 3'b010;
  localparam logic [2:0] MD_INTR  = 3'b110;

  localparam int RES_W = 12;

  function automatic int settle_ns(input logic [2:0] code);
    case (code)
      3'd0:    return 2100;
      3'd1:    return 2500;
      3'd2:    return 2700;
      3'd3:    return 3600;
      default: return 4100;
    endcase
  endfunction

  function automatic int settle_cycles(input logic [2:0] code, input int clk_mhz);
    return (settle_ns(code) * clk_mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/conv_cfg_regs.sv
module conv_cfg_regs
  import conv_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [2:0] gain_o,
  output logic [2:0] chan_o,
  output logic [2:0] mode_o,
  output logic [2:0] isel_o,
  output logic       gain_chg_o,
  output logic       sw_trig_o,
  output logic       ack_o
);
  logic [2:0] gain_q, chan_q, mode_q, isel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '0;
      chan_q <= '0;
      mode_q <= '0;
      isel_q <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        RS_GAIN: gain_q <= wr_data_i[2:0];
        RS_CHAN: chan_q <= wr_data_i[2:0];
        RS_MODE: begin
          mode_q <= wr_data_i[2:0];
          isel_q <= wr_data_i[6:4];
        end
        default: ;
      endcase
    end
  end

  assign gain_chg_o = wr_en_i && (wr_sel_i == RS_GAIN) && (wr_data_i[2:0] != gain_q);
  assign sw_trig_o  = wr_en_i && (wr_sel_i == RS_TRIG);
  assign ack_o      = wr_en_i && (wr_sel_i == RS_ACK);
  assign gain_o     = gain_q;
  assign chan_o     = chan_q;
  assign mode_o     = mode_q;
  assign isel_o     = isel_q;
endmodule

// File: rtl/conv_settle_timer.sv
module conv_settle_timer
  import conv_seq_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  localparam int MAX_CYC = (4100 * CLK_MHZ + 999) / 1000,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [2:0]       code_i,
  output logic             zero_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] tbl [8];
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < 8; g++) begin : g_tbl
    assign tbl[g] = CNT_W'(settle_cycles(3'(g), CLK_MHZ));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= tbl[code_i];
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_seq_pkg::*;
#(
  parameter int OVR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_trig_i,
  input  logic             pacer_i,
  input  logic [2:0]       mode_i,
  input  logic             settle_zero_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] data_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             cplt_o,
  output logic [RES_W-1:0] res_o,
  output logic [OVR_W-1:0] ovr_o
);
  sq_state_e        st_q, st_d;
  logic [RES_W-1:0] res_q;
  logic [OVR_W-1:0] ovr_q;
  logic             sw_en, pac_en, trig;

  assign sw_en  = (mode_i == MD_SW_A) || (mode_i == MD_SW_B);
  assign pac_en = (mode_i == MD_PACER) || (mode_i == MD_INTR);
  assign trig   = (sw_en && sw_trig_i) || (pac_en && pacer_i);

  assign start_o = (st_q == SQ_WAIT) && settle_zero_i;
  assign cplt_o  = (st_q == SQ_CONV) && done_i;
  assign busy_o  = (st_q != SQ_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE: if (trig)          st_d = SQ_WAIT;
      SQ_WAIT: if (settle_zero_i) st_d = SQ_CONV;
      SQ_CONV: if (done_i)        st_d = SQ_IDLE;
      default:                    st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      res_q <= '0;
      ovr_q <= '0;
    end else begin
      st_q <= st_d;
      if (cplt_o) res_q <= data_i;
      if (trig && busy_o && (ovr_q != '1)) ovr_q <= ovr_q + 1'b1;
    end
  end

  assign res_o = res_q;
  assign ovr_o = ovr_q;
endmodule

// File: rtl/conv_irq_route.sv
module conv_irq_route
  import conv_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cplt_i,
  input  logic [2:0] mode_i,
  input  logic       ack_i,
  input  logic [2:0] isel_i,
  output logic [7:0] irq_o
);
  logic flag_q, intr_en;

  assign intr_en = (mode_i == MD_INTR);

  // completion wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (cplt_i && intr_en) flag_q <= 1'b1;
    else if (ack_i)             flag_q <= 1'b0;
  end

  always_comb begin
    irq_o = '0;
    if (flag_q && intr_en) begin
      case (isel_i)
        3'b000, 3'b010: irq_o[2] = 1'b1;
        3'b001:         irq_o    = '0;
        default:        irq_o[isel_i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
  import conv_seq_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int OVR_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_sel_i,
  output logic [7:0]       rd_data_o,
  input  logic             pacer_i,
  output logic             conv_start_o,
  output logic [2:0]       conv_chan_o,
  output logic [2:0]       conv_gain_o,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             busy_o,
  output logic [7:0]       irq_o,
  output logic [OVR_W-1:0] overrun_o
);
  localparam int MAX_CYC = (4100 * CLK_MHZ + 999) / 1000;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [2:0]       gain_q, chan_q, mode_q, isel_q;
  logic             gain_chg, sw_trig, ack, settle_zero, cplt;
  logic [CNT_W-1:0] settle_cnt;
  logic [RES_W-1:0] res;

  conv_cfg_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .gain_o(gain_q), .chan_o(chan_q), .mode_o(mode_q), .isel_o(isel_q),
    .gain_chg_o(gain_chg), .sw_trig_o(sw_trig), .ack_o(ack)
  );

  conv_settle_timer #(.CLK_MHZ(CLK_MHZ)) u_settle (
    .clk_i, .rst_ni, .load_i(gain_chg), .code_i(wr_data_i[2:0]),
    .zero_o(settle_zero), .cnt_o(settle_cnt)
  );

  conv_seq_fsm #(.OVR_W(OVR_W)) u_fsm (
    .clk_i, .rst_ni, .sw_trig_i(sw_trig), .pacer_i, .mode_i(mode_q),
    .settle_zero_i(settle_zero), .done_i(conv_done_i), .data_i(conv_data_i),
    .start_o(conv_start_o), .busy_o, .cplt_o(cplt), .res_o(res), .ovr_o(overrun_o)
  );

  conv_irq_route u_irq (
    .clk_i, .rst_ni, .cplt_i(cplt), .mode_i(mode_q), .ack_i(ack),
    .isel_i(isel_q), .irq_o
  );

  assign rd_data_o   = rd_sel_i ? {3'b000, busy_o, res[11:8]} : res[7:0];
  assign conv_chan_o = chan_q;
  assign conv_gain_o = gain_q;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int OVR_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             conv_start_o,
  input logic             busy_o,
  input logic [7:0]       irq_o,
  input logic [OVR_W-1:0] overrun_o,
  input logic [2:0]       mode_q,
  input logic [CNT_W-1:0] settle_cnt
);
  a_r3_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  a_r3_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> busy_o);
  a_r6_ovr_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (overrun_o >= $past(overrun_o)));
  a_r7_hold_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settle_cnt != '0) |-> !conv_start_o);
  a_r10_one_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  a_r9_irq_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != 3'b110) |-> (irq_o == '0));
endmodule

bind conv_seq_top conv_seq_chk #(.OVR_W(OVR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .conv_start_o(conv_start_o), .busy_o(busy_o),
  .irq_o(irq_o), .overrun_o(overrun_o), .mode_q(mode_q), .settle_cnt(settle_cnt)
);

// File: tb/sim_conv_seq_top.sv
`timescale 1ns/1ps
module sim_conv_seq_top;
  localparam int LAT = 20;
  localparam logic [11:0] RVEC [5] = '{12'h000, 12'hFFF, 12'hA5C, 12'h801, 12'h37E};

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_sel = 0, pacer = 0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0, rd_data, irq, ovr;
  logic        start, busy, done = 0;
  logic [2:0]  chan, gain;
  logic [11:0] cdata = '0, model_data = '0;
  int          lat = 0, total = 0, bad = 0;
  bit          ended = 0;

  always #10 clk = ~clk;

  conv_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .pacer_i(pacer), .conv_start_o(start),
    .conv_chan_o(chan), .conv_gain_o(gain), .conv_done_i(done), .conv_data_i(cdata),
    .busy_o(busy), .irq_o(irq), .overrun_o(ovr)
  );

  // converter model
  always @(posedge clk) begin
    done <= 1'b0;
    if (start) lat <= LAT;
    else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin done <= 1'b1; cdata <= model_data; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_pacer();
    pacer = 1;
    @(negedge clk);
    pacer = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  function automatic logic [7:0] line_of(input logic [2:0] s);
    if (s == 3'd1) return 8'h00;
    if (s == 3'd0 || s == 3'd2) return 8'h04;
    return 8'(1) << s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    rd(0, v); chk("R1 low", v, 0);
    rd(1, v); chk("R1 high", v, 0);
    chk("R1 irq", irq, 0); chk("R1 ovr", ovr, 0);
    chk("R1 chan", chan, 0); chk("R1 gain", gain, 0);

    // R2/R3 vector table: software trigger, read back both bytes
    foreach (RVEC[i]) begin
      model_data = RVEC[i];
      wr(3'd3, 8'(i * 37));
      chk("R3 start", start, 1);
      @(negedge clk);
      chk("R3 one pulse", start, 0);
      rd(1, v); chk("R2 busy bit", v, 8'h10 | {4'h0, RVEC[i > 0 ? i-1 : 0][11:8] & {4{i > 0}}});
      wait_idle();
      rd(0, v); chk("R2 low byte", v, RVEC[i][7:0]);
      rd(1, v); chk("R2 high byte", v, {4'h0, RVEC[i][11:8]});
    end

    // R4 sources disabled by mode
    wr(3'd2, 8'h02);
    wr(3'd3, 8'hFF);
    chk("R4 sw in pacer mode start", start, 0); chk("R4 sw in pacer mode busy", busy, 0);
    wr(3'd2, 8'h00);
    pulse_pacer();
    chk("R4 pacer in sw mode", busy, 0);
    wr(3'd2, 8'h03);
    pulse_pacer(); chk("R4 mode 011 pacer", busy, 0);
    wr(3'd3, 8'h00); chk("R4 mode 011 sw", busy, 0);
    chk("R4 no overrun", ovr, 0);

    // R5 pacer start
    wr(3'd2, 8'h02);
    model_data = 12'h5A5;
    pulse_pacer();
    chk("R5 pacer start", start, 1);
    // R6 second trigger while busy
    @(negedge clk);
    pulse_pacer();
    chk("R6 no restart", start, 0);
    chk("R6 overrun one", ovr, 1);
    wait_idle();
    rd(0, v); chk("R5 result", v, 8'hA5);

    // R7 settling guard
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h00);
    chk("R7 held busy", busy, 1);
    n = 1;
    while (!start && n < 1000) begin @(negedge clk); n++; end
    chk("R7 gain 2 cycles", n, 135);
    wait_idle();
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h00);
    chk("R7 same code no reload", start, 1);
    wait_idle();
    wr(3'd0, 8'hF6);
    wr(3'd3, 8'h00);
    n = 1;
    while (!start && n < 1000) begin @(negedge clk); n++; end
    chk("R7 code 110 cycles", n, 205);
    wait_idle();

    // R8 channel and gain outputs
    wr(3'd1, 8'hFD); chk("R8 chan", chan, 5);
    wr(3'd0, 8'hF3); chk("R8 gain", gain, 3);
    repeat (200) @(negedge clk);

    // R9 no flag in polled mode
    wr(3'd2, 8'h40);
    wr(3'd3, 8'h00); wait_idle();
    chk("R9 polled no irq", irq, 0);
    wr(3'd2, 8'h46);
    chk("R9 no stale flag", irq, 0);

    // R9/R10 line map
    for (int s = 0; s < 8; s++) begin
      wr(3'd2, {1'b0, 3'(s), 4'b0110});
      pulse_pacer(); wait_idle();
      chk("R10 line", irq, line_of(3'(s)));
      repeat (5) @(negedge clk);
      chk("R9 sticky", irq, line_of(3'(s)));
      wr(3'd4, 8'h5C);
      chk("R9 ack clears", irq, 0);
    end

    // R11 completion and ack on the same edge
    wr(3'd2, 8'h36);
    pulse_pacer();
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    wr(3'd4, 8'h00);
    chk("R11 set wins", irq, 8'h08);
    wr(3'd4, 8'h00);
    chk("R11 later ack clears", irq, 0);

    // R6 saturation
    wr(3'd2, 8'h02);
    pacer = 1;
    repeat (600) @(negedge clk);
    pacer = 0;
    wait_idle();
    chk("R6 saturate", ovr, 8'hFF);

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule